// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy-Chain Responder

This block is the bus-facing half of a slave card's interrupter. An interrupt controller elsewhere on the card keeps the pending flags, the per-point vectors, the programmed request level and a global enable. From these inputs the responder drives one of seven active-low request lines. It also answers the acknowledge cycle that the bus handler runs in response.

During an acknowledge cycle the grant enters on an active-low daisy-chain input, and the data strobe is asserted. The responder compares the acknowledged level on address bits A3..A1 with its own level. If the levels match and it has a request, it puts the 8-bit vector of its highest pending point on D7..D0 and asserts the data acknowledge. In any other case it passes the grant to the next card on its active-low chain output.

Answering an acknowledge does not remove the request. The request line stays low until the controller's pending flags are cleared by a register write, which is release on register access.

The state machine has four states:
- IDLE waits for a grant with the strobe asserted.
- PASS holds the chain output asserted.
- ANSWER drives the vector and the acknowledge.
- TAIL waits until both the grant and the strobe are negated.

The transitions are:
- IDLE→ANSWER on a grant with a level match.
- IDLE→PASS on a grant without a match.
- PASS→TAIL and ANSWER→TAIL when the grant or the strobe is negated.
- TAIL→IDLE when both are negated.

Top module: `dch_responder`

## Requirements
- R1: After reset, all request lines are high, the chain output is high, the acknowledge is high and the vector enable is low.
- R2: When the card is active (global enable set, level 1..7, at least one pending point), exactly the request line whose number equals the level is driven low, one clock after the inputs settle. Bit k of `irq_n` is line k.
- R3: With level 0, global enable clear or no pending point, no request line is driven low.
- R4: When the grant and the strobe are both low, the card is active and `ack_lvl` equals the level, the acknowledge goes low one clock later. The vector of the highest-numbered pending point is then on `vec_out`, with `vec_oe` high. Point p's vector is `vec_table[8p+7:8p]`, and point 7 has the highest priority.
- R5: When the grant and the strobe are both low but the level does not match or the card is inactive, the chain output goes low one clock later and the acknowledge stays high.
- R6: One clock after the grant or the strobe is negated, the chain output and the acknowledge are both high. No new decision is taken until both inputs have been high together.
- R7: The chain output and the acknowledge are never low in the same cycle, and `vec_oe` is high only while the acknowledge is low.
- R8: Answering an acknowledge leaves the request line asserted. The line is released one clock after the pending points are cleared.
- R9: The vector is captured at the decision. It stays stable for the whole answer, even if the pending flags change during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 3 | Programmed request level, 0 = off |
| cfg_glb_en | input | 1 | Global interrupt enable |
| pend | input | 8 | Pending points from the controller |
| vec_table | input | 64 | Eight 8-bit vectors, point p at bits 8p+7..8p |
| iackin_n | input | 1 | Daisy-chain grant in, active low |
| ds_n | input | 1 | Data strobe, active low |
| ack_lvl | input | 3 | Acknowledged level from A3..A1 |
| irq_n | output | 7 | Request lines 1..7, active low |
| iackout_n | output | 1 | Daisy-chain grant out, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| vec_out | output | 8 | Vector for D7..D0 |
| vec_oe | output | 1 | Vector drive enable |

## Verification
On every cycle, the assertions check the following:
- At most one request line is low.
- An inactive card is silent on the next cycle.
- The chain output and the acknowledge are mutually exclusive.
- Both are released after a negated grant or strobe.
- The chain output is only asserted while both inputs are low.
- An acknowledge always follows a match.
- The vector is stable during an answer.

Only the bench's scenarios can show that the right card of a two-card chain wins, that the returned vector belongs to the highest pending point, and that the request survives the acknowledge. The bench sweeps every level pair over several pending patterns to show these.

// File: rtl/dch_pkg.sv
package dch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PASS   = 2'd1,
        ST_ANSWER = 2'd2,
        ST_TAIL   = 2'd3
    } dch_state_e;
endpackage

// File: rtl/dch_prio.sv
module dch_prio #(
    parameter int NPTS = 8,
    localparam int IW  = (NPTS > 1) ? $clog2(NPTS) : 1
) (
    input  logic [NPTS-1:0] pend,
    output logic [IW-1:0]   win_idx
);
    // Scan upward: a later (higher) point overrides, so the top point wins.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NPTS; i++) begin
            if (pend[i]) win_idx = IW'(i);
        end
    end
endmodule

// File: rtl/dch_irq_drive.sv
module dch_irq_drive #(
    parameter int LW     = 3,
    localparam int NLINE = (1 << LW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [LW-1:0] level,
    output logic [NLINE:1] irq_n
);
    for (genvar g = 1; g <= NLINE; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) irq_n[g] <= 1'b1;
            else        irq_n[g] <= !(active && (level == LW'(g)));
        end
    end

    // R2: at most one request line is driven at any time
    a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n) <= 1);
    // R3: an inactive card releases every line on the next cycle
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (&irq_n));
endmodule

// File: rtl/dch_ack_fsm.sv
module dch_ack_fsm
    import dch_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iackin_n,
    input  logic          ds_n,
    input  logic          match,
    input  logic [VW-1:0] vec_in,
    output logic          iackout_n,
    output logic          dtack_n,
    output logic [VW-1:0] vec_out,
    output logic          vec_oe
);
    dch_state_e state_q, state_d;
    logic [VW-1:0] vec_q;
    logic granted;

    assign granted = !iackin_n && !ds_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (granted) state_d = match ? ST_ANSWER : ST_PASS;
            ST_PASS:   if (!granted) state_d = ST_TAIL;
            ST_ANSWER: if (!granted) state_d = ST_TAIL;
            ST_TAIL:   if (iackin_n && ds_n) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && granted && match) vec_q <= vec_in;
        end
    end

    always_comb begin
        iackout_n = 1'b1;
        dtack_n   = 1'b1;
        vec_oe    = 1'b0;
        vec_out   = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PASS:   iackout_n = 1'b0;
            ST_ANSWER: begin
                dtack_n = 1'b0;
                vec_oe  = 1'b1;
                vec_out = vec_q;
            end
            ST_TAIL:   ;
            default:   ;
        endcase
    end

    // R7: grant forwarding and acknowledge are mutually exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iackout_n && !dtack_n));
    // R7: vector enable only while acknowledging
    a_r7_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !dtack_n);
    // R6: a negated grant or strobe releases both outputs next cycle
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (iackin_n || ds_n) |=> (iackout_n && dtack_n));
    // R5: forwarding only follows a live grant with strobe
    a_r5_pass_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iackout_n) |-> $past(!iackin_n && !ds_n));
    // R4: an acknowledge starts only after a level match
    a_r4_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(match));
    // R9: the vector does not move during an answer
    a_r9_stable_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && $past(!dtack_n)) |-> $stable(vec_out));
endmodule

// File: rtl/dch_responder.sv
module dch_responder #(
    parameter int NPTS = 8,
    parameter int VW   = 8,
    parameter int LW   = 3,
    localparam int NLINE = (1 << LW) - 1,
    localparam int IW    = (NPTS > 1) ? $clog2(NPTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LW-1:0]     cfg_level,
    input  logic              cfg_glb_en,
    input  logic [NPTS-1:0]   pend,
    input  logic [NPTS*VW-1:0] vec_table,
    input  logic              iackin_n,
    input  logic              ds_n,
    input  logic [LW-1:0]     ack_lvl,
    output logic [NLINE:1]    irq_n,
    output logic              iackout_n,
    output logic              dtack_n,
    output logic [VW-1:0]     vec_out,
    output logic              vec_oe
);
    logic          active;
    logic          match;
    logic [IW-1:0] win_idx;
    logic [VW-1:0] vtab [NPTS];

    assign active = cfg_glb_en && (cfg_level != '0) && (|pend);
    assign match  = active && (ack_lvl == cfg_level);

    for (genvar g = 0; g < NPTS; g++) begin : g_vec
        assign vtab[g] = vec_table[g*VW +: VW];
    end

    dch_prio #(.NPTS(NPTS)) u_prio (
        .pend    (pend),
        .win_idx (win_idx)
    );

    dch_irq_drive #(.LW(LW)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .level  (cfg_level),
        .irq_n  (irq_n)
    );

    dch_ack_fsm #(.VW(VW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .iackin_n  (iackin_n),
        .ds_n      (ds_n),
        .match     (match),
        .vec_in    (vtab[win_idx]),
        .iackout_n (iackout_n),
        .dtack_n   (dtack_n),
        .vec_out   (vec_out),
        .vec_oe    (vec_oe)
    );
endmodule

// File: tb/sim_dch_responder.sv
module sim_dch_responder;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [2:0] a_level, b_level, ack_lvl;
    logic       a_en, b_en, iackin_n, ds_n;
    logic [7:0] a_pend, b_pend;
    logic [63:0] a_vtab, b_vtab;
    logic [7:1] a_irq, b_irq;
    logic       a_iackout, b_iackout, a_dtack, b_dtack, a_oe, b_oe;
    logic [7:0] a_vec, b_vec;

    int n_tests = 0;
    int n_fail  = 0;

    dch_responder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_level(a_level), .cfg_glb_en(a_en),
        .pend(a_pend), .vec_table(a_vtab), .iackin_n(iackin_n), .ds_n(ds_n),
        .ack_lvl(ack_lvl), .irq_n(a_irq), .iackout_n(a_iackout),
        .dtack_n(a_dtack), .vec_out(a_vec), .vec_oe(a_oe)
    );
    dch_responder u1 (
        .clk(clk), .rst_n(rst_n), .cfg_level(b_level), .cfg_glb_en(b_en),
        .pend(b_pend), .vec_table(b_vtab), .iackin_n(a_iackout), .ds_n(ds_n),
        .ack_lvl(ack_lvl), .irq_n(b_irq), .iackout_n(b_iackout),
        .dtack_n(b_dtack), .vec_out(b_vec), .vec_oe(b_oe)
    );

    // Wired bus views
    logic [7:1] bus_irq;
    logic [7:0] bus_data;
    logic       bus_dtack;
    assign bus_irq   = a_irq & b_irq;
    assign bus_dtack = a_dtack & b_dtack;
    assign bus_data  = a_oe ? a_vec : (b_oe ? b_vec : 8'h00);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic int top_pt(input logic [7:0] p);
        int r = -1;
        for (int i = 0; i < 8; i++) if (p[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:1] exp_irq(input logic [2:0] la, input logic ea, input logic [7:0] pa,
                                           input logic [2:0] lb, input logic eb, input logic [7:0] pb);
        logic [7:1] r = 7'h7F;
        if (ea && la != 0 && pa != 0) r[la] = 1'b0;
        if (eb && lb != 0 && pb != 0) r[lb] = 1'b0;
        return r;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One acknowledge cycle at level al, with expected winner computed here
    task automatic ack_cycle(input logic [2:0] al);
        logic a_act, b_act, a_win, b_win;
        logic [7:0] exp_vec;
        a_act = a_en && a_level != 0 && a_pend != 0;
        b_act = b_en && b_level != 0 && b_pend != 0;
        a_win = a_act && (al == a_level);
        b_win = !a_win && b_act && (al == b_level);
        exp_vec = 8'h00;
        if (a_win) exp_vec = 8'h40 + 8'(3 * top_pt(a_pend));
        else if (b_win) exp_vec = 8'h90 + 8'(top_pt(b_pend));
        ack_lvl = al; iackin_n = 1'b0; ds_n = 1'b0;
        step(3);
        chk("R4 card0 dtack", a_dtack, !a_win);
        chk("R4 card1 dtack", b_dtack, !b_win);
        chk("R5 card0 iackout", a_iackout, a_win);
        chk("R5 chain end iackout", b_iackout, a_win || b_win);
        chk("R4 vector", bus_data, exp_vec);
        chk("R7 exclusive", (!a_iackout && !a_dtack) || (!b_iackout && !b_dtack), 0);
        iackin_n = 1'b1; ds_n = 1'b1;
        step(1);
        chk("R6 release", {a_iackout, a_dtack, b_iackout, b_dtack, a_oe, b_oe}, 6'b111100);
        step(1);
        chk("R8 irq kept", bus_irq, exp_irq(a_level, a_en, a_pend, b_level, b_en, b_pend));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pats [3];
        pats[0] = 8'h00; pats[1] = 8'h81; pats[2] = 8'h1C;
        for (int i = 0; i < 8; i++) begin
            a_vtab[i*8 +: 8] = 8'h40 + 8'(3 * i);
            b_vtab[i*8 +: 8] = 8'h90 + 8'(i);
        end
        rst_n = 1'b0; iackin_n = 1'b1; ds_n = 1'b1; ack_lvl = 3'd0;
        a_level = 3'd0; a_en = 1'b0; a_pend = 8'h00;
        b_level = 3'd5; b_en = 1'b1; b_pend = 8'h06;
        step(3);
        chk("R1 reset irq", a_irq, 7'h7F);
        chk("R1 reset outs", {a_iackout, a_dtack, a_oe}, 3'b110);
        rst_n = 1'b1;

        // Sweep card0 level, enable and pending pattern against every acknowledged level
        for (int la = 0; la < 8; la++)
            for (int en = 0; en < 2; en++)
                for (int p = 0; p < 3; p++) begin
                    a_level = 3'(la); a_en = en[0]; a_pend = pats[p];
                    step(2);
                    chk("R2 R3 irq lines", bus_irq, exp_irq(a_level, a_en, a_pend, b_level, b_en, b_pend));
                    for (int al = 1; al < 8; al++) ack_cycle(3'(al));
                end

        // R9: vector held while pending flags change mid-answer
        a_level = 3'd3; a_en = 1'b1; a_pend = 8'h81;
        step(2);
        ack_lvl = 3'd3; iackin_n = 1'b0; ds_n = 1'b0;
        step(2);
        chk("R9 vector at start", bus_data, 8'h55);
        a_pend = 8'h01;
        step(2);
        chk("R9 vector held", bus_data, 8'h55);
        chk("R9 ack held", bus_dtack, 1'b0);
        // R6: strobe alone negated with grant still low
        ds_n = 1'b1;
        step(1);
        chk("R6 strobe release", {a_dtack, a_oe}, 2'b10);
        ds_n = 1'b0;
        step(2);
        chk("R6 no re-entry", {a_dtack, a_iackout}, 2'b11);
        iackin_n = 1'b1; ds_n = 1'b1;
        step(2);

        // R8: clearing pending flags releases the lines
        chk("R8 before clear", bus_irq, exp_irq(3, 1, 8'h01, 5, 1, 8'h06));
        a_pend = 8'h00; b_pend = 8'h00;
        step(2);
        chk("R8 after clear", bus_irq, 7'h7F);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule